// File: doc/BRIEF.md
# Power-of-Two Oversampling Averager

This block sits on the path from a 10-bit converter to the per-sequence result buffers. It takes raw conversions of the current step, adds a group of 2^k of them, and divides the total by shifting it right k bits. It then emits one 10-bit averaged result. The exponent k comes from a 3-bit control input. A value of 0 passes every raw sample through unchanged. Values above 6 are limited to 6, so the largest factor is 64. The output rate is the raw rate divided by 2^k.

One setting covers every step of every sequence. The sequencer pulses `step_start` when it moves to a new step (a new channel). That pulse clears the partial sum and the sample count, so samples from different channels never mix. The same pulse is the only moment at which a new `avg_log` value is taken up. After each raw sample that does not close a group, the block pulses `more_req` to ask the sequencer to restart the converter.

Both data paths are valid/ready streams. A raw sample is taken in a cycle where `raw_valid` and `raw_ready` are both high. A result stays on `res_data` with `res_valid` high, unchanged, until a cycle where `res_ready` is high. While a result is waiting, `raw_ready` is low, so the converter side is held back.

Top module: `sample_averager`

## Requirements
- R1: After reset, `res_valid` and `more_req` are 0, `raw_ready` is 1, and the exponent in use is 0 (pass-through) until the first `step_start`.
- R2: With exponent 0, a sample taken in cycle t appears on `res_data` with `res_valid` high from cycle t+1, with the same value.
- R3: With exponent k (0..6), `res_valid` rises in the cycle after the 2^k-th sample taken since the last group or `step_start`. `res_data` is then floor(sum of those samples / 2^k).
- R4: An `avg_log` value of 7 is used as 6, which gives groups of 64 samples.
- R5: `avg_log` is sampled only in a cycle where `step_start` is 1. A change at any other time has no effect on the group in progress or on later groups of the same step.
- R6: `step_start` throws away any partial sum and count. A sample taken in the same cycle as `step_start` is the first sample of the new step's group.
- R7: `more_req` is high for exactly the one cycle after each sample taken that does not complete a group. It stays low after a sample that completes a group.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_data` holds its value and `raw_ready` is 0. `res_valid` falls in the cycle after `res_ready` is seen high.
- R9: Sixty-four samples of 1023 at exponent 6 give a result of 1023. The 16-bit sum does not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| avg_log | input | 3 | Oversampling exponent k; the factor is 2^k; values above 6 count as 6 |
| step_start | input | 1 | Pulse at the start of a new step; clears the group and loads `avg_log` |
| raw_valid | input | 1 | A raw conversion is present |
| raw_ready | output | 1 | The block can take a raw conversion |
| raw_data | input | 10 | Raw conversion value |
| res_valid | output | 1 | An averaged result is present |
| res_ready | input | 1 | The downstream side takes the result |
| res_data | output | 10 | Averaged result |
| more_req | output | 1 | One-cycle request for another raw conversion |

## Verification
Some properties are checked by the assertions on every cycle:
- the held result stays stable and the input is stalled under back-pressure;
- the sample count stays below the group size;
- the stored exponent never goes above 6;
- no `more_req` follows a completed group;
- pass-through produces a result on the next cycle.

Other properties depend on values seen over many cycles, so only the bench's scenarios can show them. These are the averaged values themselves, the limit on large exponents, the rule that a changed exponent waits for the next step, and the discarding of a partial group at a step boundary. A cycle-level reference model tracks all of these.

// File: rtl/avg_pkg.sv
package avg_pkg;
  localparam int DATA_W  = 10;
  localparam int MAX_LOG = 6;
  localparam int SEL_W   = 3;
  localparam int ACC_W   = DATA_W + MAX_LOG;
  localparam int CNT_W   = MAX_LOG;
endpackage

// File: rtl/avg_cfg.sv
module avg_cfg
  import avg_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int ML = MAX_LOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_start,
  input  logic [SW-1:0] avg_log,
  output logic [SW-1:0] log_now,
  output logic [SW-1:0] log_q
);
  logic [SW-1:0] sel_lim;

  always_comb begin
    sel_lim = (avg_log > SW'(ML)) ? SW'(ML) : avg_log;
    log_now = step_start ? sel_lim : log_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          log_q <= '0;
    else if (step_start) log_q <= sel_lim;
  end

  assert_log_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    log_q <= SW'(ML));
endmodule

// File: rtl/avg_accum.sv
module avg_accum
  import avg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int ML = MAX_LOG,
  parameter int SW = SEL_W,
  localparam int AW = DW + ML,
  localparam int CW = ML
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic [SW-1:0] log_now,
  input  logic [DW-1:0] sample,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          more_req
);
  logic [AW-1:0] acc_q, acc_base, sum, shifted;
  logic [CW-1:0] cnt_q, cnt_base;
  logic [CW:0]   one, mask;
  logic          last;

  always_comb begin
    one      = {{CW{1'b0}}, 1'b1};
    mask     = (one << log_now) - one;
    acc_base = clear ? '0 : acc_q;
    cnt_base = clear ? '0 : cnt_q;
    sum      = acc_base + {{(AW-DW){1'b0}}, sample};
    last     = ({1'b0, cnt_base} == mask);
    shifted  = sum >> log_now;
    result   = shifted[DW-1:0];
    done     = take && last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      more_req <= 1'b0;
    end else begin
      more_req <= take && !last;
      if (take && last) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (take) begin
        acc_q <= sum;
        cnt_q <= cnt_base + CW'(1);
      end else if (clear) begin
        acc_q <= '0;
        cnt_q <= '0;
      end
    end
  end

  assert_count_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> ({1'b0, cnt_q} <= mask));
  assert_no_more_after_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !more_req);
endmodule

// File: rtl/avg_out.sv
module avg_out
  import avg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          res_ready,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          can_take
);
  assign can_take = !res_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_data  <= load_data;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
endmodule

// File: rtl/sample_averager.sv
module sample_averager
  import avg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int ML = MAX_LOG,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] avg_log,
  input  logic          step_start,
  input  logic          raw_valid,
  output logic          raw_ready,
  input  logic [DW-1:0] raw_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          more_req
);
  logic [SW-1:0] log_now, log_q;
  logic          take, done;
  logic [DW-1:0] result;

  assign take = raw_valid && raw_ready;

  avg_cfg #(.SW(SW), .ML(ML)) cfg_i (
    .clk(clk), .rst_n(rst_n), .step_start(step_start), .avg_log(avg_log),
    .log_now(log_now), .log_q(log_q)
  );

  avg_accum #(.DW(DW), .ML(ML), .SW(SW)) acc_i (
    .clk(clk), .rst_n(rst_n), .clear(step_start), .take(take),
    .log_now(log_now), .sample(raw_data), .done(done), .result(result),
    .more_req(more_req)
  );

  avg_out #(.DW(DW)) out_i (
    .clk(clk), .rst_n(rst_n), .load(done), .load_data(result),
    .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data),
    .can_take(raw_ready)
  );

  assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !step_start && log_q == '0) |=> (res_valid && res_data == $past(raw_data)));
  assert_stall_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> !raw_ready);
endmodule

// File: tb/sample_averager_tb.sv
module sample_averager_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] avg_log = 3'd0;
  logic       step_start = 1'b0;
  logic       raw_valid = 1'b0;
  logic [9:0] raw_data = '0;
  logic       res_ready = 1'b1;
  logic       raw_ready, res_valid, more_req;
  logic [9:0] res_data;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  // reference model state
  int  m_log, m_sum, m_cnt, m_data;
  bit  m_valid, m_more;

  always #4 clk = ~clk;

  sample_averager dut_i (
    .clk(clk), .rst_n(rst_n), .avg_log(avg_log), .step_start(step_start),
    .raw_valid(raw_valid), .raw_ready(raw_ready), .raw_data(raw_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .more_req(more_req)
  );

  always @(posedge clk) begin
    bit rdy, acc;
    if (!rst_n) begin
      m_log = 0; m_sum = 0; m_cnt = 0; m_data = 0; m_valid = 0; m_more = 0;
    end else begin
      rdy = !m_valid;
      acc = raw_valid && rdy;
      if (step_start) begin
        m_log = (avg_log > 6) ? 6 : int'(avg_log);
        m_sum = 0; m_cnt = 0;
      end
      m_more = 0;
      if (m_valid && res_ready) m_valid = 0;
      if (acc) begin
        m_sum += int'(raw_data);
        m_cnt++;
        if (m_cnt == (1 << m_log)) begin
          m_valid = 1; m_data = m_sum >> m_log; m_sum = 0; m_cnt = 0;
        end else m_more = 1;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("res_valid", int'(res_valid), int'(m_valid));
      chk("more_req", int'(more_req), int'(m_more));
      chk("raw_ready", int'(raw_ready), int'(!m_valid));
      if (m_valid) chk("res_data", int'(res_data), m_data);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic send(int d);
    bit ok;
    raw_valid = 1'b1;
    raw_data = 10'(d);
    forever begin
      ok = raw_ready;
      @(negedge clk);
      if (ok) break;
    end
    raw_valid = 1'b0;
  endtask

  task automatic new_step(int k);
    step_start = 1'b1;
    avg_log = 3'(k);
    @(negedge clk);
    step_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    chk("reset res_valid", int'(res_valid), 0);
    chk("reset more_req", int'(more_req), 0);
    chk("reset raw_ready", int'(raw_ready), 1);
    // R2 pass-through with reset exponent (no step_start)
    cur_req = "R2";
    send(5); send(1023); send(0); send(77);
    chk("R2 last value", int'(res_data), 77);
    @(negedge clk);
    // R3 and R7: factor 8 with varied data
    cur_req = "R3/R7";
    new_step(3);
    for (int i = 0; i < 16; i++) send((i * 37 + 11) % 1024);
    @(negedge clk);
    new_step(1);
    for (int i = 0; i < 6; i++) send(i * 3 + 1);
    @(negedge clk);
    // R4 and R9: avg 7 treated as 6, full-scale
    cur_req = "R4/R9";
    new_step(7);
    for (int i = 0; i < 64; i++) send(1023);
    chk("R9 full scale", int'(res_data), 1023);
    @(negedge clk);
    // R5: change mid-step ignored
    cur_req = "R5";
    new_step(2);
    send(10); send(20);
    avg_log = 3'd0;
    send(30); send(41);
    chk("R5 group of four", int'(res_data), 25);
    send(1); send(2); send(3); send(6);
    chk("R5 still four", int'(res_data), 3);
    @(negedge clk);
    // R6: step_start discards partial, same-cycle sample counts
    cur_req = "R6";
    new_step(2);
    send(100); send(100); send(100);
    step_start = 1'b1; avg_log = 3'd2;
    raw_valid = 1'b1; raw_data = 10'd4;
    @(negedge clk);
    step_start = 1'b0; raw_valid = 1'b0;
    send(8); send(12); send(16);
    chk("R6 fresh group", int'(res_data), 10);
    @(negedge clk);
    // R8: back-pressure
    cur_req = "R8";
    new_step(0);
    res_ready = 1'b0;
    raw_valid = 1'b1; raw_data = 10'd300;
    @(negedge clk);
    raw_data = 10'd400;
    repeat (4) begin
      chk("R8 held data", int'(res_data), 300);
      chk("R8 stalled", int'(raw_ready), 0);
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    raw_valid = 1'b0;
    chk("R8 next value", int'(res_data), 400);
    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule